// File: doc/BRIEF.md
# Segment Limit and Rights Checker

This block validates one memory reference per clock against a segment descriptor that is already held in the core, and turns the reference into a linear address. It receives the descriptor's base, its 20-bit limit, the granularity and default-size flags, and the access-rights fields: present, descriptor privilege, code/data selector and the 3-bit kind code. It also receives the reference itself: a 32-bit offset, an access size, an access kind and the requester's privilege level.

It answers one cycle later. The answer is either a valid linear address or a single fault code. The fault code covers a missing descriptor, a forbidden kind of access, insufficient privilege, or an offset outside the segment. Downward-growing stack segments are handled, with their upper bound chosen by the default-size flag. Page-granular limits are scaled to their byte extent.

Top module: `seg_check`

## Requirements
- R1: For a request with no fault, `valid_o` is 1 in the cycle after the request and `lin_addr_o` equals `base_i + offset_i` modulo 2^32, with `fault_o` = 0.
- R2: In the cycle after a clock edge without `req_i`, `valid_o` is 0, `fault_o` is 0 and `lin_addr_o` is 0. After reset all three are 0.
- R3: If `present_i` is 0, the result is fault code 1 (not present), whatever the other descriptor fields hold.
- R4: A present descriptor with `code_data_i` = 0 (a system descriptor) gives fault code 2 (type).
- R5: The kind code `seg_type_i` works as follows. Values 0 and 1 are data, 2 and 3 are stack, and 4 to 7 are code. Bit 0 grants write for data and stack, and grants read for code. Fetch (`kind_i` = 2) on data or stack, write (`kind_i` = 1) on code, write on data or stack with bit 0 clear, and read (`kind_i` = 0 or 3) on code with bit 0 clear all give fault code 2.
- R6: For seg_type_i values 0 to 5, a request with `rpl_i` > `dpl_i` gives fault code 3 (privilege). The conforming code values 6 and 7 skip this comparison.
- R7: For every kind except stack, with `gran_i` = 0, every byte from offset to offset + 2^`size_i` - 1 must be at most `limit_i`. Otherwise the result is fault code 4 (limit). `size_i` 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R8: With `gran_i` = 1, the effective limit is `limit_i` * 4096 + 4095 for both the expand-up and the expand-down checks.
- R9: For stack kinds (2 and 3), the offset must be strictly greater than the effective limit. The last byte must be at most 0xFFFF when `big_i` = 0, or at most 0xFFFFFFFF when `big_i` = 1. Otherwise the result is fault code 4.
- R10: Only the highest-ranking fault is reported, in the order not present, type, privilege, limit. When a fault is reported, `valid_o` is 0 and `lin_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | A reference is presented this cycle |
| base_i | input | 32 | Segment base |
| limit_i | input | 20 | Segment limit field |
| gran_i | input | 1 | Page-granular limit |
| big_i | input | 1 | 32-bit default size (stack upper bound) |
| present_i | input | 1 | Descriptor present |
| dpl_i | input | 2 | Descriptor privilege level |
| code_data_i | input | 1 | 1 = code/data/stack descriptor, 0 = system |
| seg_type_i | input | 3 | Segment kind code |
| offset_i | input | 32 | Reference offset |
| size_i | input | 2 | log2 of access bytes |
| kind_i | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| rpl_i | input | 2 | Requester privilege level |
| lin_addr_o | output | 32 | Linear address, 0 unless valid |
| valid_o | output | 1 | Result valid without fault |
| fault_o | output | 3 | 0 none, 1 not present, 2 type, 3 privilege, 4 limit |

## Verification
The assertions take for granted that the input fields are stable and meaningful in any cycle where `req_i` is high. They do not assume the descriptor fields are consistent with each other. Any kind code may meet any access kind and privilege, and system descriptors may arrive marked present. The stimulus drives every field across its full range. It biases offsets and limits toward the edges: offsets just below, at and beyond the limit, and offsets near 0xFFFF and 0xFFFFFFFF, so that the multi-byte end-of-access cases and the wrap of the 32-bit sum are reached. Idle cycles are mixed in at random.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned LIM_W   = 20;
  localparam int unsigned GRAN_SH = 12;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_NP    = 3'd1,
    FLT_TYPE  = 3'd2,
    FLT_PRIV  = 3'd3,
    FLT_LIMIT = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_READ2 = 2'd3
  } acc_e;
endpackage

// File: rtl/seg_rights_chk.sv
module seg_rights_chk (
  input  logic       present_i,
  input  logic       code_data_i,
  input  logic [2:0] seg_type_i,
  input  logic [1:0] kind_i,
  input  logic [1:0] rpl_i,
  input  logic [1:0] dpl_i,
  output logic       np_flt_o,
  output logic       type_flt_o,
  output logic       priv_flt_o,
  output logic       stack_o
);
  import seg_pkg::*;
  logic is_code, conforming, perm_bit, is_fetch, is_write, is_read;

  always_comb begin
    is_code    = seg_type_i[2];
    conforming = seg_type_i[2] & seg_type_i[1];
    perm_bit   = seg_type_i[0];
    is_fetch   = (kind_i == ACC_FETCH);
    is_write   = (kind_i == ACC_WRITE);
    is_read    = ~is_fetch & ~is_write;
    stack_o    = ~seg_type_i[2] & seg_type_i[1];
    np_flt_o   = ~present_i;
    type_flt_o = ~code_data_i
               | (is_fetch & ~is_code)
               | (is_write & is_code)
               | (is_write & ~is_code & ~perm_bit)
               | (is_read  & is_code & ~perm_bit);
    // conforming code ignores the privilege comparison
    priv_flt_o = ~conforming & (rpl_i > dpl_i);
  end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LIM_W   = 20,
  parameter int unsigned GRAN_SH = 12
) (
  input  logic              gran_i,
  input  logic              big_i,
  input  logic              stack_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [1:0]        size_i,
  output logic              lim_flt_o
);
  localparam int unsigned EXT_W = ADDR_W + 1;
  localparam int unsigned PAD_W = ADDR_W - LIM_W - GRAN_SH;

  logic [ADDR_W-1:0] lim_eff;
  logic [EXT_W-1:0]  last_byte, upper;
  logic [3:0]        bytes_m1;

  always_comb begin
    if (gran_i) lim_eff = {{PAD_W{1'b0}}, limit_i, {GRAN_SH{1'b1}}};
    else        lim_eff = {{(ADDR_W-LIM_W){1'b0}}, limit_i};
    bytes_m1  = (4'd1 << size_i) - 4'd1;
    last_byte = {1'b0, offset_i} + {{(EXT_W-4){1'b0}}, bytes_m1};
    upper     = big_i ? {1'b0, {ADDR_W{1'b1}}} : {{(EXT_W-16){1'b0}}, 16'hFFFF};
    if (stack_i)
      lim_flt_o = (offset_i <= lim_eff) | (last_byte > upper);
    else
      lim_flt_o = (last_byte > {1'b0, lim_eff});
  end
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int unsigned ADDR_W  = seg_pkg::ADDR_W,
  parameter int unsigned LIM_W   = seg_pkg::LIM_W,
  parameter int unsigned GRAN_SH = seg_pkg::GRAN_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              gran_i,
  input  logic              big_i,
  input  logic              present_i,
  input  logic [1:0]        dpl_i,
  input  logic              code_data_i,
  input  logic [2:0]        seg_type_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        kind_i,
  input  logic [1:0]        rpl_i,
  output logic [ADDR_W-1:0] lin_addr_o,
  output logic              valid_o,
  output logic [2:0]        fault_o
);
  import seg_pkg::*;

  logic np_flt, type_flt, priv_flt, lim_flt, stack;
  fault_e fault_d;

  seg_rights_chk u_rights (
    .present_i   (present_i),
    .code_data_i (code_data_i),
    .seg_type_i  (seg_type_i),
    .kind_i      (kind_i),
    .rpl_i       (rpl_i),
    .dpl_i       (dpl_i),
    .np_flt_o    (np_flt),
    .type_flt_o  (type_flt),
    .priv_flt_o  (priv_flt),
    .stack_o     (stack)
  );

  seg_limit_chk #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .GRAN_SH(GRAN_SH)) u_limit (
    .gran_i    (gran_i),
    .big_i     (big_i),
    .stack_i   (stack),
    .limit_i   (limit_i),
    .offset_i  (offset_i),
    .size_i    (size_i),
    .lim_flt_o (lim_flt)
  );

  always_comb begin
    if      (np_flt)   fault_d = FLT_NP;
    else if (type_flt) fault_d = FLT_TYPE;
    else if (priv_flt) fault_d = FLT_PRIV;
    else if (lim_flt)  fault_d = FLT_LIMIT;
    else               fault_d = FLT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_addr_o <= '0;
      valid_o    <= 1'b0;
      fault_o    <= FLT_NONE;
    end else if (req_i) begin
      valid_o    <= (fault_d == FLT_NONE);
      fault_o    <= fault_d;
      lin_addr_o <= (fault_d == FLT_NONE) ? base_i + offset_i : '0;
    end else begin
      valid_o    <= 1'b0;
      fault_o    <= FLT_NONE;
      lin_addr_o <= '0;
    end
  end
endmodule

// File: rtl/seg_check_sva.sv
module seg_check_sva #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIM_W  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] base_i,
  input logic              present_i,
  input logic              code_data_i,
  input logic [2:0]        seg_type_i,
  input logic [ADDR_W-1:0] offset_i,
  input logic [1:0]        kind_i,
  input logic [ADDR_W-1:0] lin_addr_o,
  input logic              valid_o,
  input logic [2:0]        fault_o
);
  p_addr_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (valid_o ? (lin_addr_o == $past(base_i + offset_i)) : (lin_addr_o == '0)));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && fault_o == 3'd0 && lin_addr_o == '0));

  p_not_present_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !present_i) |=> (fault_o == 3'd1 && !valid_o));

  p_system_type_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && present_i && !code_data_i) |=> (fault_o == 3'd2));

  p_fetch_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && present_i && !seg_type_i[2] && kind_i == 2'd2) |=> (fault_o == 3'd2));

  p_conform_skip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && seg_type_i[2:1] == 2'b11) |=> (fault_o != 3'd3));

  p_valid_clean_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (fault_o == 3'd0));
endmodule

bind seg_check seg_check_sva #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .base_i      (base_i),
  .present_i   (present_i),
  .code_data_i (code_data_i),
  .seg_type_i  (seg_type_i),
  .offset_i    (offset_i),
  .kind_i      (kind_i),
  .lin_addr_o  (lin_addr_o),
  .valid_o     (valid_o),
  .fault_o     (fault_o)
);

// File: tb/seg_check_tb.sv
module seg_check_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] base_i = '0, offset_i = '0;
  logic [19:0] limit_i = '0;
  logic        gran_i = 0, big_i = 0, present_i = 0, code_data_i = 0;
  logic [1:0]  dpl_i = '0, size_i = '0, kind_i = '0, rpl_i = '0;
  logic [2:0]  seg_type_i = '0;
  logic [31:0] lin_addr_o;
  logic        valid_o;
  logic [2:0]  fault_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  seg_check u_dut (.*);

  // behavioural model
  function automatic int model_fault();
    longint eff, last, top;
    bit code, wr, fe, rd;
    if (!present_i) return 1;
    if (!code_data_i) return 2;
    code = seg_type_i >= 4;
    wr = (kind_i == 1); fe = (kind_i == 2); rd = !wr && !fe;
    if (fe && !code) return 2;
    if (wr && code) return 2;
    if (wr && (seg_type_i % 2 == 0)) return 2;
    if (rd && code && (seg_type_i % 2 == 0)) return 2;
    if (seg_type_i < 6 && rpl_i > dpl_i) return 3;
    eff  = gran_i ? longint'(limit_i) * 4096 + 4095 : longint'(limit_i);
    last = longint'(offset_i) + (longint'(1) << size_i) - 1;
    if (seg_type_i == 2 || seg_type_i == 3) begin
      top = big_i ? 64'hFFFF_FFFF : 64'hFFFF;
      if (longint'(offset_i) <= eff || last > top) return 4;
    end else if (last > eff) return 4;
    return 0;
  endfunction

  task automatic check(string tag, bit ok, string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // expected result of the previous cycle
  bit          exp_req = 0;
  int          exp_flt = 0;
  logic [31:0] exp_addr = '0;
  string       exp_tag = "R2";

  task automatic capture();
    exp_req = req_i;
    exp_flt = req_i ? model_fault() : 0;
    exp_addr = (req_i && exp_flt == 0) ? base_i + offset_i : 32'h0;
    if (!req_i) exp_tag = "R2";
    else case (exp_flt)
      0: exp_tag = "R1"; 1: exp_tag = "R3"; 2: exp_tag = "R5";
      3: exp_tag = "R6"; default: exp_tag = (seg_type_i == 2 || seg_type_i == 3) ? "R9" : "R7";
    endcase
  endtask

  task automatic compare();
    check(exp_tag, fault_o == 3'(exp_flt) && valid_o == (exp_req && exp_flt == 0)
          && lin_addr_o == exp_addr,
          $sformatf("got f=%0d v=%0b a=%h exp f=%0d v=%0b a=%h", fault_o, valid_o, lin_addr_o,
                    exp_flt, exp_req && exp_flt == 0, exp_addr));
  endtask

  // one request: drive at negedge, check on next negedge
  task automatic issue(bit rq, logic [31:0] b, logic [19:0] l, bit g, bit d, bit p, logic [1:0] dpl,
                       bit s, logic [2:0] t, logic [31:0] o, logic [1:0] sz, logic [1:0] k,
                       logic [1:0] r, int want, string tag);
    req_i = rq; base_i = b; limit_i = l; gran_i = g; big_i = d; present_i = p; dpl_i = dpl;
    code_data_i = s; seg_type_i = t; offset_i = o; size_i = sz; kind_i = k; rpl_i = r;
    capture();
    if (want >= 0)
      check(tag, exp_flt == want, $sformatf("model f=%0d exp %0d", exp_flt, want));
    @(negedge clk_i);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R2", !valid_o && fault_o == 0 && lin_addr_o == 0,
          $sformatf("reset v=%0b f=%0d a=%h exp 0 0 0", valid_o, fault_o, lin_addr_o));
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 plain read with address wrap
    issue(1, 32'hFFFF_FF00, 20'hFFFFF, 1, 1, 1, 0, 1, 3'd1, 32'h0000_0200, 2, 0, 0, 0, "R1");
    // R2 idle
    issue(0, 32'h1234, 20'h10, 0, 0, 1, 0, 1, 3'd1, 32'h4, 0, 0, 0, -1, "R2");
    // R3 not present beats everything
    issue(1, 0, 0, 0, 0, 0, 0, 0, 3'd4, 32'hFFFF_FFFF, 3, 1, 3, 1, "R3");
    // R4 system descriptor
    issue(1, 0, 20'hFFFFF, 1, 1, 1, 3, 0, 3'd1, 0, 0, 0, 0, 2, "R4");
    // R5 table
    issue(1, 0, 20'hFFFFF, 1, 1, 1, 3, 1, 3'd0, 0, 0, 1, 0, 2, "R5");
    issue(1, 0, 20'hFFFFF, 1, 1, 1, 3, 1, 3'd4, 0, 0, 0, 0, 2, "R5");
    issue(1, 0, 20'hFFFFF, 1, 1, 1, 3, 1, 3'd5, 0, 0, 3, 0, 0, "R5");
    issue(1, 0, 20'hFFFFF, 1, 1, 1, 3, 1, 3'd3, 0, 0, 2, 0, 2, "R5");
    // R6 privilege and conforming skip
    issue(1, 0, 20'hFFFFF, 1, 1, 1, 1, 1, 3'd5, 0, 0, 2, 2, 3, "R6");
    issue(1, 0, 20'hFFFFF, 1, 1, 1, 1, 1, 3'd6, 0, 0, 2, 3, 0, "R6");
    // R10 type outranks privilege; privilege outranks limit
    issue(1, 0, 20'h0, 0, 0, 1, 0, 1, 3'd0, 32'h100, 0, 1, 3, 2, "R10");
    issue(1, 0, 20'h0, 0, 0, 1, 0, 1, 3'd1, 32'h100, 0, 1, 3, 3, "R10");
    // R7 last byte at and past the limit
    issue(1, 32'h10, 20'h00FF, 0, 0, 1, 0, 1, 3'd1, 32'hFC, 2, 0, 0, 0, "R7");
    issue(1, 32'h10, 20'h00FF, 0, 0, 1, 0, 1, 3'd1, 32'hFD, 2, 0, 0, 4, "R7");
    // R8 granular limit fills low bits
    issue(1, 0, 20'h00001, 1, 0, 1, 0, 1, 3'd1, 32'h1FFF, 0, 1, 0, 0, "R8");
    issue(1, 0, 20'h00001, 1, 0, 1, 0, 1, 3'd1, 32'h2000, 0, 1, 0, 4, "R8");
    // R9 expand-down
    issue(1, 32'h5000, 20'h0FFF, 0, 0, 1, 0, 1, 3'd3, 32'h0FFF, 0, 1, 0, 4, "R9");
    issue(1, 32'h5000, 20'h0FFF, 0, 0, 1, 0, 1, 3'd3, 32'h1000, 0, 1, 0, 0, "R9");
    issue(1, 32'h5000, 20'h0FFF, 0, 0, 1, 0, 1, 3'd3, 32'hFFFE, 1, 1, 0, 0, "R9");
    issue(1, 32'h5000, 20'h0FFF, 0, 0, 1, 0, 1, 3'd3, 32'hFFFE, 2, 1, 0, 4, "R9");
    issue(1, 32'h5000, 20'h0FFF, 0, 1, 1, 0, 1, 3'd2, 32'hFFFE, 2, 0, 0, 0, "R9");
    issue(1, 32'h5000, 20'h0FFF, 0, 1, 1, 0, 1, 3'd2, 32'hFFFF_FFFD, 2, 0, 0, 4, "R9");
    issue(1, 0, 20'h00000, 1, 1, 1, 0, 1, 3'd2, 32'h0FFF, 0, 0, 0, 4, "R8");
    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [19:0] l = $urandom;
      logic [31:0] o;
      bit g = $urandom_range(0, 1);
      int sel = $urandom_range(0, 5);
      logic [31:0] eff = g ? {l, 12'hFFF} : {12'h0, l};
      case (sel)
        0: o = eff - $urandom_range(0, 8);
        1: o = eff + $urandom_range(0, 8);
        2: o = 32'hFFFF - $urandom_range(0, 8);
        3: o = 32'hFFFF_FFFF - $urandom_range(0, 8);
        default: o = $urandom;
      endcase
      issue($urandom_range(0, 7) != 0, $urandom, l, g, $urandom_range(0, 1),
            $urandom_range(0, 15) != 0, 2'($urandom), $urandom_range(0, 15) != 0,
            3'($urandom), o, 2'($urandom), 2'($urandom), 2'($urandom), -1, "");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule